// File: doc/BRIEF.md
# Clock-Source Control Register

This block is a small memory-mapped register set that turns four clock sources on and off. The four sources are a multi-speed internal oscillator, a 16 MHz internal oscillator, an external oscillator and a main PLL. For each source it holds an enable bit and a ready bit. It also selects the frequency range of the multi-speed oscillator, and it raises ready interrupts under per-source enables. Ready is modelled as an immediate copy of enable. The block does not model the real settling time of an oscillator or the lock time of the PLL.

Two inputs are sampled on every write to the control register. The first is the system-clock switch status. The second is the PLL input-source code. A source that currently drives the system clock, directly or through the PLL, cannot be switched off by software:

- The two internal oscillators are forced on.
- The external oscillator and the PLL keep their enable bit set.

A range code outside the table of twelve legal codes is refused, and the previous range code stays in place.

The bus is a single-cycle write port with a registered read port. Read data appears one clock after the address is presented. Word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | Control | read/write |
| 1 | Standby range | read/write |
| 2 | Interrupt enable | read/write |
| 3 | Interrupt flags | read-only |
| 4 | Flag clear | write 1 to clear, reads as 0 |

Source index `i` is 0 for the multi-speed oscillator, 1 for the 16 MHz oscillator, 2 for the external oscillator and 3 for the PLL.

Top module: `clk_src_ctrl`

## Requirements
- R1: After a synchronous reset, the state is as follows. Only the multi-speed oscillator is enabled and ready. The control range code and the standby range code are both 6, and `range_sel` is 0. Interrupt enables and flags are 0, and `irq` is 0.
- R2: The control register has a fixed bit layout. Bit `2*i` is the enable of source `i` and bit `2*i+1` is its ready. Bit 8 is `range_sel` and bits 15:12 are the range code. A source that is neither forced nor held takes the written enable, its ready equals that enable, and its `*_on` output shows the enable.
- R3: The PLL is held on while the switch status is 3 (PLL). A control write then leaves the PLL enable at 1, leaves its ready unchanged, and sets no PLL flag.
- R4: The external oscillator is held on while the switch status is 2 or the PLL source code is 3. A control write then leaves its enable at 1, leaves its ready unchanged, and sets no flag for it.
- R5: The 16 MHz oscillator is forced on while the switch status is 1 or the PLL source code is 2. A control write then sets its enable and ready to 1 whatever was written, and sets its flag when its interrupt enable is 1.
- R6: The multi-speed oscillator is forced on while the switch status is 0 or the PLL source code is 1. A control write then sets its enable and ready to 1. Its flag is set only if its enable was 0 before the write and its interrupt enable is 1.
- R7: For a source that is neither forced nor held, a control write sets that source's flag when the written enable is 1 and its interrupt-enable bit is 1.
- R8: The `msi_range` output shows the control range code when `range_sel` is 1, and the standby range code otherwise.
- R9: A control write whose range field is 12 or more leaves the control range code at its previous value. Codes 0 to 11 are stored.
- R10: A standby-range write of 12 or more leaves the standby code at its previous value. Codes 0 to 11 are stored.
- R11: Writing 1s to the clear address clears those flag bits, where bit `i` belongs to source `i`. `irq` is the OR over all sources of flag AND interrupt enable.
- R12: Bus writes never change the ready bits or the flag register directly. Written ready bits are ignored, and a write to the flag address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the address of the previous cycle |
| sws | input | 2 | System-clock switch status: 0 multi-speed, 1 16 MHz, 2 external, 3 PLL |
| pll_src | input | 2 | PLL input: 0 none, 1 multi-speed, 2 16 MHz, 3 external |
| msi_on | output | 1 | Multi-speed oscillator enable |
| hsi_on | output | 1 | 16 MHz oscillator enable |
| ext_on | output | 1 | External oscillator enable |
| pll_on | output | 1 | PLL enable |
| msi_range | output | RANGE_W | Active multi-speed range code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four sources, a 4-bit range field and twelve legal codes. With these values every one of the 16 possible range codes can be written to both range registers, so all four illegal codes are covered. The bench also sweeps every combination of switch status, PLL source and written enable pattern, both with all interrupts enabled and with none enabled. Forced, held and free sources therefore each meet every prior state that the walk produces.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int N_SRC   = 4;
  localparam int SRC_MSI = 0;
  localparam int SRC_HSI = 1;
  localparam int SRC_EXT = 2;
  localparam int SRC_PLL = 3;

  typedef enum logic [1:0] {
    SW_MSI = 2'd0,
    SW_HSI = 2'd1,
    SW_EXT = 2'd2,
    SW_PLL = 2'd3
  } sw_stat_e;

  typedef enum logic [1:0] {
    PIN_NONE = 2'd0,
    PIN_MSI  = 2'd1,
    PIN_HSI  = 2'd2,
    PIN_EXT  = 2'd3
  } pll_in_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_STBY = 1;
  localparam int ADR_IE   = 2;
  localparam int ADR_FLAG = 3;
  localparam int ADR_CLR  = 4;

  localparam int CTRL_SEL_BIT   = 8;
  localparam int CTRL_RANGE_LSB = 12;
endpackage

// File: rtl/ccr_src_update.sv
module ccr_src_update import ccr_pkg::*; #(
  parameter int             NS             = N_SRC,
  parameter logic [NS-1:0]  FIRST_SET_MASK = 4'b0001
) (
  input  logic [1:0]    sws,
  input  logic [1:0]    pll_in,
  input  logic [NS-1:0] wr_en,
  input  logic [NS-1:0] prev_en,
  input  logic [NS-1:0] prev_rdy,
  input  logic [NS-1:0] ie,
  output logic [NS-1:0] nxt_en,
  output logic [NS-1:0] nxt_rdy,
  output logic [NS-1:0] set_flag
);
  logic [NS-1:0] force_on;
  logic [NS-1:0] hold_on;

  // Which source is in use, directly or through the PLL.
  always_comb begin
    force_on = '0;
    hold_on  = '0;
    force_on[SRC_MSI] = (sws == SW_MSI) || (pll_in == PIN_MSI);
    force_on[SRC_HSI] = (sws == SW_HSI) || (pll_in == PIN_HSI);
    hold_on[SRC_EXT]  = (sws == SW_EXT) || (pll_in == PIN_EXT);
    hold_on[SRC_PLL]  = (sws == SW_PLL);
  end

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      if (force_on[i]) begin
        nxt_en[i]   = 1'b1;
        nxt_rdy[i]  = 1'b1;
        set_flag[i] = ie[i] & (~FIRST_SET_MASK[i] | ~prev_en[i]);
      end else if (hold_on[i]) begin
        nxt_en[i]   = 1'b1;
        nxt_rdy[i]  = prev_rdy[i];
        set_flag[i] = 1'b0;
      end else begin
        nxt_en[i]   = wr_en[i];
        nxt_rdy[i]  = wr_en[i];
        set_flag[i] = wr_en[i] & ie[i];
      end
    end
  end
endmodule

// File: rtl/ccr_range_guard.sv
module ccr_range_guard #(
  parameter int RANGE_W     = 4,
  parameter int RANGE_CODES = 12
) (
  input  logic               sel_q,
  input  logic [RANGE_W-1:0] cand_ctrl,
  input  logic [RANGE_W-1:0] cur_ctrl,
  input  logic [RANGE_W-1:0] cand_stby,
  input  logic [RANGE_W-1:0] cur_stby,
  output logic               keep_ctrl,
  output logic               keep_stby,
  output logic [RANGE_W-1:0] active
);
  localparam logic [RANGE_W:0] CODE_LIM = (RANGE_W+1)'(RANGE_CODES);

  assign keep_ctrl = !({1'b0, cand_ctrl} < CODE_LIM);
  assign keep_stby = !({1'b0, cand_stby} < CODE_LIM);
  assign active    = sel_q ? cur_ctrl : cur_stby;
endmodule

// File: rtl/ccr_irq_unit.sv
module ccr_irq_unit #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ie_we,
  input  logic [NS-1:0] ie_d,
  input  logic          clr_we,
  input  logic [NS-1:0] clr_d,
  input  logic [NS-1:0] set_mask,
  output logic [NS-1:0] ie_q,
  output logic [NS-1:0] flag_q,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      flag_q <= '0;
    end else begin
      if (ie_we) ie_q <= ie_d;
      flag_q <= (flag_q | set_mask) & ~(clr_we ? clr_d : '0);
    end
  end

  assign irq = |(flag_q & ie_q);

  // R11: cleared bits read back as zero after a clear write
  a_r11_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr_we && set_mask == '0) |=> ((flag_q & $past(clr_d)) == '0));

  // R12: no flag bit appears without a set request
  a_r12_no_stray_flag: assert property (@(posedge clk) disable iff (rst)
    (set_mask == '0) |=> ((flag_q & ~$past(flag_q)) == '0));
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl import ccr_pkg::*; #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int RANGE_W     = 4,
  parameter int RANGE_CODES = 12,
  parameter int RESET_RANGE = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [1:0]         sws,
  input  logic [1:0]         pll_src,
  output logic               msi_on,
  output logic               hsi_on,
  output logic               ext_on,
  output logic               pll_on,
  output logic [RANGE_W-1:0] msi_range,
  output logic               irq
);
  localparam int NS = N_SRC;
  localparam logic [RANGE_W-1:0] RST_CODE = RANGE_W'(RESET_RANGE);
  localparam logic [RANGE_W:0]   CODE_LIM = (RANGE_W+1)'(RANGE_CODES);

  logic [NS-1:0]      en_q, rdy_q, nxt_en, nxt_rdy, set_flag, wr_en;
  logic [NS-1:0]      ie_q, flag_q;
  logic               sel_q;
  logic [RANGE_W-1:0] range_q, stby_q;
  logic [DATA_W-1:0]  rdata_q, rd_mux;
  logic               keep_ctrl, keep_stby;
  logic               ctrl_we, stby_we, ie_we, clr_we;

  assign ctrl_we = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
  assign stby_we = bus_we && (bus_addr == ADDR_W'(ADR_STBY));
  assign ie_we   = bus_we && (bus_addr == ADDR_W'(ADR_IE));
  assign clr_we  = bus_we && (bus_addr == ADDR_W'(ADR_CLR));

  always_comb begin
    for (int i = 0; i < NS; i++) wr_en[i] = bus_wdata[2*i];
  end

  ccr_src_update #(.NS(NS)) u_src (
    .sws(sws), .pll_in(pll_src), .wr_en(wr_en), .prev_en(en_q),
    .prev_rdy(rdy_q), .ie(ie_q), .nxt_en(nxt_en), .nxt_rdy(nxt_rdy),
    .set_flag(set_flag)
  );

  ccr_range_guard #(.RANGE_W(RANGE_W), .RANGE_CODES(RANGE_CODES)) u_rng (
    .sel_q(sel_q),
    .cand_ctrl(bus_wdata[CTRL_RANGE_LSB +: RANGE_W]), .cur_ctrl(range_q),
    .cand_stby(bus_wdata[RANGE_W-1:0]), .cur_stby(stby_q),
    .keep_ctrl(keep_ctrl), .keep_stby(keep_stby), .active(msi_range)
  );

  ccr_irq_unit #(.NS(NS)) u_irq (
    .clk(clk), .rst(rst), .ie_we(ie_we), .ie_d(bus_wdata[NS-1:0]),
    .clr_we(clr_we), .clr_d(bus_wdata[NS-1:0]),
    .set_mask(ctrl_we ? set_flag : '0),
    .ie_q(ie_q), .flag_q(flag_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL)) begin
      for (int i = 0; i < NS; i++) begin
        rd_mux[2*i]   = en_q[i];
        rd_mux[2*i+1] = rdy_q[i];
      end
      rd_mux[CTRL_SEL_BIT] = sel_q;
      rd_mux[CTRL_RANGE_LSB +: RANGE_W] = range_q;
    end else if (bus_addr == ADDR_W'(ADR_STBY)) begin
      rd_mux[RANGE_W-1:0] = stby_q;
    end else if (bus_addr == ADDR_W'(ADR_IE)) begin
      rd_mux[NS-1:0] = ie_q;
    end else if (bus_addr == ADDR_W'(ADR_FLAG)) begin
      rd_mux[NS-1:0] = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= NS'(1) << SRC_MSI;
      rdy_q   <= NS'(1) << SRC_MSI;
      sel_q   <= 1'b0;
      range_q <= RST_CODE;
      stby_q  <= RST_CODE;
      rdata_q <= '0;
    end else begin
      if (ctrl_we) begin
        en_q  <= nxt_en;
        rdy_q <= nxt_rdy;
        sel_q <= bus_wdata[CTRL_SEL_BIT];
        if (!keep_ctrl) range_q <= bus_wdata[CTRL_RANGE_LSB +: RANGE_W];
      end
      if (stby_we && !keep_stby) stby_q <= bus_wdata[RANGE_W-1:0];
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign msi_on = en_q[SRC_MSI];
  assign hsi_on = en_q[SRC_HSI];
  assign ext_on = en_q[SRC_EXT];
  assign pll_on = en_q[SRC_PLL];

  // R3: PLL cannot be dropped while it drives the system clock
  a_r3_pll_held: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && sws == SW_PLL) |=> pll_on);

  // R4: external oscillator cannot be dropped while in use
  a_r4_ext_held: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && (sws == SW_EXT || pll_src == PIN_EXT)) |=> ext_on);

  // R5: 16 MHz oscillator forced on and ready while in use
  a_r5_hsi_forced: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && (sws == SW_HSI || pll_src == PIN_HSI)) |=> (hsi_on && rdy_q[SRC_HSI]));

  // R6: multi-speed oscillator forced on and ready while in use
  a_r6_msi_forced: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && (sws == SW_MSI || pll_src == PIN_MSI)) |=> (msi_on && rdy_q[SRC_MSI]));

  // R2: a free external oscillator has ready equal to enable
  a_r2_ext_follow: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && sws != SW_EXT && pll_src != PIN_EXT) |=> (rdy_q[SRC_EXT] == ext_on));

  // R9: the control range code never leaves the legal table
  a_r9_range_legal: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, range_q} < CODE_LIM));

  // R10: the standby range code never leaves the legal table
  a_r10_stby_legal: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, stby_q} < CODE_LIM));
endmodule

// File: tb/clk_src_ctrl_test.sv
module clk_src_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  sws = 2'd0;
  logic [1:0]  pll_src = 2'd0;
  logic        msi_on, hsi_on, ext_on, pll_on, irq;
  logic [3:0]  msi_range;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [3:0] m_en, m_rdy, m_flag, m_ie;
  logic       m_sel;
  logic [3:0] m_rng, m_stby;

  clk_src_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sws(sws),
    .pll_src(pll_src), .msi_on(msi_on), .hsi_on(hsi_on), .ext_on(ext_on),
    .pll_on(pll_on), .msi_range(msi_range), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word();
    logic [31:0] v = '0;
    for (int i = 0; i < 4; i++) begin
      v[2*i] = m_en[i];
      v[2*i+1] = m_rdy[i];
    end
    v[8] = m_sel;
    v[15:12] = m_rng;
    return v;
  endfunction

  // Expected effect of a control write, from R2..R7.
  task automatic model_ctrl(input logic [1:0] s, input logic [1:0] p, input logic [3:0] w);
    logic [3:0] ne, nr, st;
    for (int i = 0; i < 4; i++) begin
      bit frc = (i == 0 && (s == 0 || p == 1)) || (i == 1 && (s == 1 || p == 2));
      bit hld = (i == 2 && (s == 2 || p == 3)) || (i == 3 && s == 3);
      if (frc) begin
        ne[i] = 1; nr[i] = 1;
        st[i] = m_ie[i] && (i != 0 || !m_en[i]);
      end else if (hld) begin
        ne[i] = 1; nr[i] = m_rdy[i]; st[i] = 0;
      end else begin
        ne[i] = w[i]; nr[i] = w[i]; st[i] = w[i] & m_ie[i];
      end
    end
    m_en = ne; m_rdy = nr; m_flag = m_flag | st;
  endtask

  function automatic logic [31:0] ctrl_data(input logic [3:0] w, input logic sel, input logic [3:0] rng);
    logic [31:0] v = '0;
    for (int i = 0; i < 4; i++) begin
      v[2*i] = w[i];
      v[2*i+1] = ~w[i];
    end
    v[8] = sel;
    v[15:12] = rng;
    return v;
  endfunction

  task automatic do_ctrl(input logic [1:0] s, input logic [1:0] p, input logic [3:0] w,
                         input logic sel, input logic [3:0] rng);
    sws = s; pll_src = p;
    bus_wr(3'd0, ctrl_data(w, sel, rng));
    model_ctrl(s, p, w);
    m_sel = sel;
    if (rng < 12) m_rng = rng;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    m_en = 4'b0001; m_rdy = 4'b0001; m_flag = 0; m_ie = 0;
    m_sel = 0; m_rng = 6; m_stby = 6;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(3'd0, rd); chk("R1 ctrl", rd, 32'h0000_6003);
    bus_rd(3'd1, rd); chk("R1 stby", rd, 32'd6);
    bus_rd(3'd2, rd); chk("R1 ie", rd, 32'd0);
    bus_rd(3'd3, rd); chk("R1 flags", rd, 32'd0);
    chk("R1 pins", {pll_on, ext_on, hsi_on, msi_on, irq}, 5'b00010);
    chk("R1 range", msi_range, 4'd6);

    // R2..R7, R12: sweep of status, PLL source and written enables
    for (int ie = 0; ie < 2; ie++) begin
      m_ie = ie ? 4'hF : 4'h0;
      bus_wr(3'd2, m_ie);
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++)
          for (int w = 0; w < 16; w++) begin
            do_ctrl(s[1:0], p[1:0], w[3:0], 1'b0, 4'd6);
            chk("R2 pins", {pll_on, ext_on, hsi_on, msi_on}, m_en);
            chk("R11 irq", irq, |(m_flag & m_ie));
            bus_rd(3'd0, rd); chk("R2/R12 ctrl readback", rd, ctrl_word());
            bus_rd(3'd3, rd); chk("R7 flags", rd, m_flag);
            bus_wr(3'd4, 32'hF); m_flag = 0;
          end
    end

    // R6 flag only on a first forcing
    m_ie = 4'hF; bus_wr(3'd2, m_ie);
    do_ctrl(2'd1, 2'd0, 4'b0000, 1'b0, 4'd6);
    chk("R6 msi off before forcing", msi_on, 1'b0);
    bus_wr(3'd4, 32'hF); m_flag = 0;
    do_ctrl(2'd0, 2'd0, 4'b0000, 1'b0, 4'd6);
    bus_rd(3'd3, rd); chk("R6 first forcing flag", rd, 32'h1);
    bus_wr(3'd4, 32'hF); m_flag = 0;
    do_ctrl(2'd0, 2'd0, 4'b0000, 1'b0, 4'd6);
    bus_rd(3'd3, rd); chk("R6 repeat forcing no flag", rd, 32'h0);

    // R11 partial clear and irq gating, R12 flag register write ignored
    do_ctrl(2'd1, 2'd0, 4'b1101, 1'b0, 4'd6);
    bus_rd(3'd3, rd); chk("R7 all flags", rd, 32'hF);
    bus_wr(3'd3, 32'h0);
    bus_rd(3'd3, rd); chk("R12 flag write ignored", rd, 32'hF);
    bus_wr(3'd4, 32'h5);
    bus_rd(3'd3, rd); chk("R11 partial clear", rd, 32'hA);
    chk("R11 irq on", irq, 1'b1);
    bus_wr(3'd2, 32'h0);
    chk("R11 irq masked", irq, 1'b0);
    bus_wr(3'd2, 32'h2);
    chk("R11 irq one enable", irq, 1'b1);
    bus_wr(3'd4, 32'hA);
    bus_rd(3'd3, rd); chk("R11 cleared", rd, 32'h0);
    chk("R11 irq off", irq, 1'b0);
    m_ie = 4'h2; m_flag = 0;

    // R10 standby range sweep, R8 selection with range_sel = 0
    do_ctrl(2'd0, 2'd0, 4'b0001, 1'b0, 4'd6);
    for (int c = 0; c < 16; c++) begin
      bus_wr(3'd1, c);
      if (c < 12) m_stby = c[3:0];
      bus_rd(3'd1, rd); chk("R10 stby", rd, m_stby);
      chk("R8 range from stby", msi_range, m_stby);
    end

    // R9 control range sweep, R8 for both selections
    for (int sel = 0; sel < 2; sel++)
      for (int c = 0; c < 16; c++) begin
        do_ctrl(2'd0, 2'd0, 4'b0001, sel[0], c[3:0]);
        bus_rd(3'd0, rd); chk("R9 ctrl range", rd[15:12], m_rng);
        chk("R8 active range", msi_range, m_sel ? m_rng : m_stby);
      end

    done = 1;
    finish_run();
  end
endmodule